// File: doc/BRIEF.md
# Cascadable Serial Motor Control Register

This block receives eight control bits for a two-channel stepping motor driver over a three-wire serial bus made of a data line, a shift clock and a latch strobe. Bits enter a shift register on each rising edge of the serial clock. A rising edge of the latch strobe copies the shift register into a storage register, and the storage register drives the motor control bits: a phase and an enable bit for each channel, plus a 4-bit torque code. An active-low clear empties both registers. A gate input forces the enables and the torque code to zero while it is high.

The serial inputs are asynchronous to the fast system clock. The block synchronizes them with a two-flop chain and detects their edges in the system clock domain. It forwards the shift clock and the latch strobe on its own outputs. The last shift stage goes out on a data output that changes only on falling serial clock edges. Because the data output moves half a serial period after the shift, a second device wired to the three outputs has a full half period of setup and hold. This lets any number of identical devices share one bus in a chain.

Top module: `serial_ctl_reg`

## Requirements
- R1: While clrN is low, the shift register, the storage register and dataOut are all zero, whatever serClk and serLatch do. As a result, ctrlOut reads 0.
- R2: On each rising edge of serClk, the level of serData enters shift stage 0, and stage i takes the old value of stage i-1, for i from 1 to 7.
- R3: dataOut changes only on a falling edge of serClk, where it takes the value of shift stage 7. It keeps its level across a rising edge of serClk.
- R4: A rising edge of serLatch copies the shift register into the storage register. Serial clock pulses without a latch, and falling edges of serLatch, leave ctrlOut unchanged.
- R5: The bit layout of ctrlOut is fixed:
  - bit 0 is the channel A phase
  - bit 1 is the channel A enable
  - bit 2 is the channel B phase
  - bit 3 is the channel B enable
  - bits 7:4 are the torque code, with bit 7 as its MSB

  A byte shifted in MSB first appears on ctrlOut with the same bit numbering.
- R6: While gateIn is high, ctrlOut bits 1, 3 and 7:4 read 0, and bits 0 and 2 show the stored phases. While gateIn is low, all eight stored bits are passed through. The gate acts combinationally, in the same cycle.
- R7: clkOut and latchOut follow serClk and serLatch with a fixed delay of 3 system clock cycles. dataOut updates on the same system clock edge at which clkOut falls.
- R8: Two devices chained through dataOut→serData, clkOut→serClk and latchOut→serLatch, and sent 16 bits and one latch, end up as follows:
  - the nearer device holds the last 8 bits sent
  - the farther device holds the first 8 bits sent
- R9: A serLatch rising edge first sampled at system clock edge j shows on ctrlOut after edge j+2, and not earlier. Every serial level held for at least 10 system clock cycles is resolved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of the synchronizers and edge detectors |
| clrN | input | 1 | Active-low asynchronous clear of the shift register, storage register and data output |
| serData | input | 1 | Serial data in |
| serClk | input | 1 | Serial shift clock in |
| serLatch | input | 1 | Serial latch strobe in |
| gateIn | input | 1 | High forces the enables and the torque code to zero |
| ctrlOut | output | 8 | Stored control bits after gating (layout in R5) |
| dataOut | output | 1 | Last shift stage, updated on falling serClk edges |
| clkOut | output | 1 | Forwarded serial clock for the next device |
| latchOut | output | 1 | Forwarded latch strobe for the next device |

## Verification
The assertions assume a few things about the inputs:
- serData is steady around each rising edge of serClk.
- Every serial level is held long enough for the synchronizers to see it, which makes the edge strobes clean single-cycle events.
- clrN is the only path that moves the registers outside those strobes.

The stimulus changes inputs only just after a falling system clock edge. It holds every serial level for 10 to 13 system cycles, chosen at random, which is at or above the 50 ns minimum pulse width. It changes serData only while serClk is low. The latch is raised only after the serial clock has returned low and settled.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W = 8;
  localparam int BIT_PHASE_A = 0;
  localparam int BIT_EN_A = 1;
  localparam int BIT_PHASE_B = 2;
  localparam int BIT_EN_B = 3;
  localparam int TRQ_LSB = 4;
  localparam int TRQ_W = REG_W - TRQ_LSB;

  // Bits left untouched by the gate: the two phases
  localparam logic [REG_W-1:0] GATE_KEEP =
    (REG_W'(1) << BIT_PHASE_A) | (REG_W'(1) << BIT_PHASE_B);

  typedef struct packed {
    logic shiftIn;   // aligned serial data bit
    logic shiftEn;   // rising serial clock seen
    logic latchEn;   // rising latch seen
    logic doutEn;    // falling serial clock seen
  } scrStrobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serData,
  input  logic serClk,
  input  logic serLatch,
  output scr_pkg::scrStrobe_t strobe,
  output logic clkOut,
  output logic latchOut
);
  localparam int LAST = SYNC_STAGES - 1;

  // lane 0: data, lane 1: clock, lane 2: latch
  logic [2:0] syncStage [SYNC_STAGES];
  logic clkPrev, latPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[g] <= '0;
          else       syncStage[g] <= {serLatch, serClk, serData};
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[g] <= '0;
          else       syncStage[g] <= syncStage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      latPrev <= 1'b0;
    end else begin
      clkPrev <= syncStage[LAST][1];
      latPrev <= syncStage[LAST][2];
    end
  end

  always_comb begin
    strobe.shiftIn = syncStage[LAST][0];
    strobe.shiftEn = syncStage[LAST][1] & ~clkPrev;
    strobe.doutEn  = ~syncStage[LAST][1] & clkPrev;
    strobe.latchEn = syncStage[LAST][2] & ~latPrev;
  end

  assign clkOut   = clkPrev;
  assign latchOut = latPrev;
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
(
  input  logic clk,
  input  logic clrN,
  input  logic gateIn,
  input  scrStrobe_t strobe,
  output logic [REG_W-1:0] ctrlOut,
  output logic dataOut
);
  logic [REG_W-1:0] shiftReg;
  logic [REG_W-1:0] storeReg;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[REG_W-2:0], strobe.shiftIn};
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)               storeReg <= '0;
    else if (strobe.latchEn) storeReg <= shiftReg;
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)              dataOut <= 1'b0;
    else if (strobe.doutEn) dataOut <= shiftReg[REG_W-1];
  end

  assign ctrlOut = gateIn ? (storeReg & GATE_KEEP) : storeReg;

  // R2: shift contents move only on a rising serial clock strobe
  a_r2_shift_hold: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.shiftEn |=> $stable(shiftReg));

  // R4: storage takes the pre-edge shift contents on a latch strobe
  a_r4_latch_copy: assert property (@(posedge clk) disable iff (!clrN)
    strobe.latchEn |=> storeReg == $past(shiftReg));

  // R4: storage holds without a latch strobe
  a_r4_store_hold: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.latchEn |=> $stable(storeReg));

  // R3: data output moves only on a falling serial clock strobe
  a_r3_dout_hold: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.doutEn |=> $stable(dataOut));

  // R3: on a falling strobe the data output takes the last stage
  a_r3_dout_load: assert property (@(posedge clk) disable iff (!clrN)
    strobe.doutEn |=> dataOut == $past(shiftReg[REG_W-1]));

  // R6: gate high leaves only the phase bits visible
  a_r6_gate_mask: assert property (@(posedge clk) disable iff (!clrN)
    gateIn |-> (ctrlOut & ~GATE_KEEP) == '0);
endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clrN,
  input  logic serData,
  input  logic serClk,
  input  logic serLatch,
  input  logic gateIn,
  output logic [7:0] ctrlOut,
  output logic dataOut,
  output logic clkOut,
  output logic latchOut
);
  scr_pkg::scrStrobe_t strobe;

  scr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .strobe(strobe), .clkOut(clkOut), .latchOut(latchOut)
  );

  scr_datapath dp_i (
    .clk(clk), .clrN(clrN), .gateIn(gateIn), .strobe(strobe),
    .ctrlOut(ctrlOut), .dataOut(dataOut)
  );
endmodule

// File: tb/serial_ctl_reg_tb.sv
`timescale 1ns/1ps
module serial_ctl_reg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0, clrN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0, gateIn = 1'b0;
  logic [7:0] ctrlOut, ctrl2;
  logic dataOut, clkOut, latchOut, d2, c2, l2;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] expShift = '0, expStore = '0;
  logic expDout = 1'b0;

  always #2.5 clk = ~clk;

  serial_ctl_reg dut_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .gateIn(gateIn), .ctrlOut(ctrlOut), .dataOut(dataOut),
    .clkOut(clkOut), .latchOut(latchOut)
  );

  serial_ctl_reg chain_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .serData(dataOut), .serClk(clkOut),
    .serLatch(latchOut), .gateIn(gateIn), .ctrlOut(ctrl2), .dataOut(d2),
    .clkOut(c2), .latchOut(l2)
  );

  function automatic logic [7:0] gated(logic [7:0] v, logic g);
    return g ? (v & 8'h05) : v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int holdLen();
    return 10 + int'($urandom_range(0, 3));
  endfunction

  task automatic pulseClk(logic d);
    serData = d;
    waitCyc(holdLen());
    serClk = 1'b1;
    waitCyc(holdLen());
    expShift = {expShift[6:0], d};
    check("R3 dout held across rise", dataOut, expDout);
    check("R7 clkOut high", clkOut, 1'b1);
    serClk = 1'b0;
    waitCyc(holdLen());
    expDout = expShift[7];
    check("R3 dout after fall", dataOut, expDout);
    check("R7 clkOut low", clkOut, 1'b0);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulseClk(b[i]);
  endtask

  task automatic doLatch();
    serLatch = 1'b1;
    waitCyc(holdLen());
    expStore = expShift;
    check("R7 latchOut high", latchOut, 1'b1);
    serLatch = 1'b0;
    waitCyc(holdLen());
    check("R4 falling latch keeps storage", ctrlOut, gated(expStore, gateIn));
  endtask

  task automatic doClear();
    clrN = 1'b0;
    serClk = 1'b1;
    serLatch = 1'b1;
    waitCyc(12);
    serClk = 1'b0;
    serLatch = 1'b0;
    waitCyc(12);
    check("R1 clear ctrlOut", ctrlOut, 8'h00);
    check("R1 clear dataOut", dataOut, 1'b0);
    clrN = 1'b1;
    expShift = '0;
    expStore = '0;
    expDout = 1'b0;
    waitCyc(4);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          failures++;
          $display("FAIL watchdog actual=timeout expected=done");
          $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(4);
    check("R1 reset ctrlOut", ctrlOut, 8'h00);
    check("R1 reset dataOut", dataOut, 1'b0);
    check("R1 reset chain ctrlOut", ctrl2, 8'h00);
    clrN = 1'b1;
    waitCyc(4);

    // R9: exact latch latency
    sendByte(8'hA5);
    @(negedge clk);
    serLatch = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 not yet visible after two edges", ctrlOut, 8'h00);
    @(posedge clk); #1;
    check("R9 visible after third edge", ctrlOut, 8'hA5);
    @(negedge clk);
    waitCyc(12);
    serLatch = 1'b0;
    waitCyc(12);
    expStore = expShift;
    check("R2 shifted byte", ctrlOut, 8'hA5);

    // R4: shifting without a latch leaves the outputs alone
    sendByte(8'h3C);
    check("R4 no latch keeps ctrlOut", ctrlOut, 8'hA5);
    doLatch();
    check("R4 latch copies", ctrlOut, 8'h3C);

    // R5: directed layout corners
    sendByte(8'h01); doLatch();
    check("R5 phaseA at bit0", ctrlOut, 8'h01);
    sendByte(8'h80); doLatch();
    check("R5 torque MSB at bit7", ctrlOut, 8'h80);
    sendByte(8'h0A); doLatch();
    check("R5 enables at bits 1 and 3", ctrlOut, 8'h0A);

    // R6: gate masking
    sendByte(8'hFF); doLatch();
    @(negedge clk); gateIn = 1'b1; #1;
    check("R6 gate high masks", ctrlOut, 8'h05);
    @(negedge clk); gateIn = 1'b0; #1;
    check("R6 gate low passes", ctrlOut, 8'hFF);

    // R1: clear while clock and latch are active
    doClear();

    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      sendByte(b);
      doLatch();
      @(negedge clk); gateIn = 1'($urandom); #1;
      check("R2 R5 R6 random byte", ctrlOut, gated(b, gateIn));
      @(negedge clk); gateIn = 1'b0;
    end

    // R8: two-device chain
    for (int k = 0; k < 4; k++) begin
      logic [7:0] far, near;
      far = (k == 0) ? 8'hC3 : 8'($urandom);
      near = (k == 0) ? 8'h5A : 8'($urandom);
      doClear();
      sendByte(far);
      sendByte(near);
      doLatch();
      waitCyc(8);
      check("R8 near device", ctrlOut, near);
      check("R8 far device", ctrl2, far);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule